// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an asynchronous static RAM of 128K bytes that shares one data bus for both directions. The host presents one request at a time: a write flag, a 17-bit address and, for writes, a byte. The host holds the request until the block answers with a one-cycle ready pulse. For a read, the byte is then on `rsp_rdata`. The block produces the active-low chip select, output enable and write strobe, and it drives the address. It splits the data bus into an outbound byte, a driver-enable for the pad and an inbound byte.

Every timing limit of the memory is a parameter counted in clock cycles. Reads hold select and output enable low for a full address-access window. The inbound byte is captured on the edge that closes that window. Writes are strobe-terminated, with output enable held high throughout, so the shorter strobe limit applies. The block's own driver turns on only after the memory's float time has passed since the strobe fell. It turns off one cycle after the strobe rises, so the two drivers on the bus never overlap.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` and `req_ready` are 0.
- R2: A read (`req_write`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles. The byte on `mem_dq_in` at the clock edge that ends those cycles is returned on `rsp_rdata`.
- R3: A write (`req_write`=1) holds `mem_we_n`=0 with `mem_ce_n`=0 for FLOAT_CYC plus DRV_CYC cycles, where DRV_CYC = max(WP_CYC-FLOAT_CYC, DV_CYC, 1). `mem_oe_n` stays 1 whenever `mem_we_n` is 0.
- R4: `mem_dq_oe` rises only after `mem_we_n` has been 0 for at least FLOAT_CYC clock edges, and it is never 1 while `mem_oe_n` is 0.
- R5: `mem_dq_oe` falls no earlier than one cycle after `mem_we_n` rises. Exactly one cycle has both `mem_dq_oe`=1 and `mem_we_n`=1.
- R6: The written byte is on `mem_dq_out`, with `mem_dq_oe`=1, for at least DV_CYC cycles before `mem_we_n` rises. The byte then reads back unchanged.
- R7: `req_ready` is a one-cycle pulse. Counting edges from the first edge that sees `req_valid`=1, it appears RD_CYC+1 edges later for a read and FLOAT_CYC+DRV_CYC+2 edges later for a write.
- R8: While `req_valid` is 0, changes on `req_write`, `req_addr` and `req_wdata` have no effect on any output.
- R9: `mem_addr` equals the accepted request's address and stays stable for as long as `mem_ce_n` is 0.
- R10: Mixed sequences of reads and writes never leave the block's driver on while the memory drives, counting the memory's float tail after output enable or chip select rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-cycle completion pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 17 | Address to the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Outbound data byte |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Inbound data byte from the pad |

## Verification
The assertions check the cycle-level rules on every cycle:
- output enable is high during every strobe;
- the driver turns on only after the float wait;
- the driver turns off only after the strobe has risen;
- the address holds while the chip is selected;
- ready lasts a single cycle.

Other properties need a memory to observe them, so only the bench's scenarios can show them. These are the returned read data, the exact access and strobe lengths, and the latency of each request type. They also include bus contention against a model that keeps driving for one cycle after it is disabled, across back-to-back mixed reads and writes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_FLOAT,
        ST_WR_DRIVE,
        ST_WR_HOLD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
        logic rdy;
    } mem_ctl_t;

    localparam mem_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0, rdy: 1'b0};

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Cycles of strobe-low with the driver on: enough for the strobe width and data setup.
    function automatic int drive_len(input int wp, input int fl, input int dv);
        return max3(wp - fl, dv, 1);
    endfunction

    function automatic mem_ctl_t ctl_of(input seq_state_e s);
        mem_ctl_t c;
        c = CTL_IDLE;
        case (s)
            ST_RD_ACC:   begin c.ce_n = 1'b0; c.oe_n = 1'b0; end
            ST_WR_FLOAT: begin c.ce_n = 1'b0; c.we_n = 1'b0; end
            ST_WR_DRIVE: begin c.ce_n = 1'b0; c.we_n = 1'b0; c.drv = 1'b1; end
            ST_WR_HOLD:  begin c.ce_n = 1'b0; c.drv = 1'b1; end
            ST_DONE:     c.rdy = 1'b1;
            default:     c = CTL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC    = 2,
    parameter int FLOAT_CYC = 1,
    parameter int DRV_CYC   = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_last,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output mem_ctl_t         ctl
);
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] FL_LOAD  = CNT_W'(FLOAT_CYC - 1);
    localparam logic [CNT_W-1:0] DRV_LOAD = CNT_W'(DRV_CYC - 1);

    seq_state_e state_q, state_d;
    mem_ctl_t   ctl_q;

    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                accept     = 1'b1;
                timer_load = 1'b1;
                if (req_write) begin
                    state_d   = ST_WR_FLOAT;
                    timer_val = FL_LOAD;
                end else begin
                    state_d   = ST_RD_ACC;
                    timer_val = RD_LOAD;
                end
            end
            ST_RD_ACC: if (timer_last) begin
                capture = 1'b1;
                state_d = ST_DONE;
            end
            ST_WR_FLOAT: if (timer_last) begin
                state_d    = ST_WR_DRIVE;
                timer_load = 1'b1;
                timer_val  = DRV_LOAD;
            end
            ST_WR_DRIVE: if (timer_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Controls are registered from the next state so every pin leaves a flop.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_IDLE;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_of(state_d);
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= mem_dq_in;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int RD_CYC    = 2,
    parameter int WP_CYC    = 2,
    parameter int FLOAT_CYC = 1,
    parameter int DV_CYC    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int DRV_CYC = drive_len(WP_CYC, FLOAT_CYC, DV_CYC);
    localparam int MAX_LEN = max3(RD_CYC, FLOAT_CYC, DRV_CYC);
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic             timer_load, timer_last, accept, capture;
    logic [CNT_W-1:0] timer_val;
    mem_ctl_t         ctl;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val), .last(timer_last)
    );

    sram_seq_fsm #(
        .RD_CYC(RD_CYC), .FLOAT_CYC(FLOAT_CYC), .DRV_CYC(DRV_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .timer_last(timer_last), .timer_load(timer_load), .timer_val(timer_val),
        .accept(accept), .capture(capture), .ctl(ctl)
    );

    sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rsp_rdata(rsp_rdata)
    );

    assign mem_ce_n  = ctl.ce_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_dq_oe = ctl.drv;
    assign req_ready = ctl.rdy;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W    = 17,
    parameter int FLOAT_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    logic [7:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst || mem_we_n)
            we_low_cnt <= '0;
        else if (we_low_cnt != 8'hFF)
            we_low_cnt <= we_low_cnt + 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    // R2
    read_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    // R3
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R4
    drive_after_float_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (32'(we_low_cnt) >= FLOAT_CYC));

    // R4
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R5
    release_after_we_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_oe) |-> $past(mem_we_n));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .FLOAT_CYC(FLOAT_CYC)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
    localparam int AW = 17, DW = 8;
    localparam int RD = 2, WP = 2, FL = 1, DV = 1;
    localparam int DRV = ((WP - FL) > DV) ? ((WP - FL) > 1 ? WP - FL : 1) : (DV > 1 ? DV : 1);

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;
    logic [AW-1:0] mem_addr;

    int tests = 0, fails = 0;
    int contention = 0, wr_timing_err = 0;

    always #2 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WP_CYC(WP), .FLOAT_CYC(FL), .DV_CYC(DV))
    u_sram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory: drives one cycle past disable, needs RD cycles of access,
    // commits on strobe rise only if strobe and data-valid widths were met.
    logic [DW-1:0] mem_model [int];
    bit   drv_tail = 0, wr_prev = 0;
    int   acc = 0, wl = 0, dvc = 0, wa = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] wd = '0;

    always @(negedge clk) begin
        bit en, wlow;
        en   = !mem_ce_n && !mem_oe_n && mem_we_n;
        wlow = !mem_ce_n && !mem_we_n;
        if ((en || drv_tail) && mem_dq_oe) contention++;
        drv_tail = en;
        if (en && mem_addr == acc_addr) acc++;
        else if (en) acc = 1;
        else acc = 0;
        acc_addr = mem_addr;
        if (en && acc >= RD)
            mem_dq_in = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
        if (wlow) begin
            wl++;
            if (mem_dq_oe) begin dvc++; wd = mem_dq_out; wa = int'(mem_addr); end
            else dvc = 0;
        end else if (wr_prev) begin
            if (wl >= WP && dvc >= DV) mem_model[wa] = wd;
            else wr_timing_err++;
            wl = 0; dvc = 0;
        end
        wr_prev = wlow;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready, "R1",
              "idle controls after reset",
              {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11100);
    endtask

    task automatic t_ignore();
        int bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            req_write = i[0];
            req_addr  = AW'(i * 4099);
            req_wdata = DW'(i * 37);
            if (!(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready)) bad++;
        end
        @(negedge clk);
        check(bad == 0 && mem_ce_n, "R8", "inputs without valid moved outputs", bad, 0);
        check(mem_ce_n && mem_we_n, "R1", "still idle", {31'd0, mem_ce_n}, 1);
    endtask

    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int lat, output int oe_low, output int we_low,
                          output int drv_cyc, output int hold_cyc, output int addr_bad);
        lat = 0; oe_low = 0; we_low = 0; drv_cyc = 0; hold_cyc = 0; addr_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (!mem_oe_n) oe_low++;
            if (!mem_we_n) we_low++;
            if (mem_dq_oe) drv_cyc++;
            if (mem_dq_oe && mem_we_n) hold_cyc++;
            if (!mem_ce_n && mem_addr != a) addr_bad++;
            if (req_ready) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat, oel, wel, drv, hold, ab;
        do_req(1'b1, a, d, lat, oel, wel, drv, hold, ab);
        check(lat == FL + DRV + 2, "R7", "write latency", lat, FL + DRV + 2);
        check(wel == FL + DRV && oel == 0, "R3", "strobe cycles / oe low", wel * 16 + oel, (FL + DRV) * 16);
        check(drv == DRV + 1, "R4", "driver cycles", drv, DRV + 1);
        check(hold == 1, "R5", "driver-on strobe-high cycles", hold, 1);
        check(ab == 0, "R9", "address mismatch cycles", ab, 0);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int lat, oel, wel, drv, hold, ab;
        do_req(1'b0, a, 8'h00, lat, oel, wel, drv, hold, ab);
        check(lat == RD + 1, "R7", "read latency", lat, RD + 1);
        check(oel == RD && wel == 0 && drv == 0, "R2", "output enable cycles", oel, RD);
        check(rsp_rdata == exp, "R6", "read data", int'(rsp_rdata), int'(exp));
        check(ab == 0, "R9", "address mismatch cycles", ab, 0);
        @(negedge clk);
        check(!req_ready, "R7", "ready pulse width", {31'd0, req_ready}, 0);
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            a = AW'(17'h0F0F0 + i);
            t_write(a, DW'(8'h40 + i * 3));
            t_read(a, DW'(8'h40 + i * 3));
        end
        t_read(17'h0F0F0, 8'h40);
        t_write(17'h00077, 8'hC3);
        check(contention == 0, "R10", "bus overlaps with memory", contention, 0);
        check(wr_timing_err == 0, "R6", "write timing violations", wr_timing_err, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ignore();
        t_write(17'h00000, 8'hA5);
        t_read(17'h00000, 8'hA5);
        t_write(17'h1FFFF, 8'h3C);
        t_write(17'h12345, 8'h81);
        t_read(17'h1FFFF, 8'h3C);
        t_read(17'h12345, 8'h81);
        t_read(17'h00000, 8'hA5);
        t_read(17'h0ABCD, 8'h00);
        t_mixed();
        repeat (3) @(negedge clk);
        t_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule